// File: doc/BRIEF.md
# Interrupt CPU Target Register Bank

This block keeps, for every interrupt line of an interrupt distributor, an 8-bit mask that names the processors the line may be sent to. Software reaches the masks through a byte-addressed window where the byte offset is the interrupt number. A word access touches four neighbouring interrupts at once, one per byte lane. A byte access touches exactly one interrupt.

The lowest 32 interrupts are private to each processor. Their masks cannot be written, and a read of them returns the accessing processor's own bit. Every stored mask is clipped to the processors that are currently online. For each shared line the block also resolves a single destination processor index, which the forwarding logic downstream consumes. Offsets at or beyond the configured interrupt count behave as empty space.

Top module: `irq_target_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every shared mask, every destination index and `rd_data` are zero.
- R2: A word access (`acc_wide`=1) ignores the two low address bits and covers interrupts base..base+3. Byte lane i, bits [8i+7:8i], belongs to interrupt base+i for both write data and read data.
- R3: A byte access (`acc_wide`=0) covers only the interrupt at `acc_addr`. It takes its write data from bits [7:0], returns the mask in bits [7:0], and reads bits [31:8] as zero.
- R4: A write to any interrupt below 32 leaves the stored state unchanged. A read of such an interrupt returns 1 shifted left by `acc_cpu` in its lane.
- R5: A written byte is ANDed with a mask of `cpus_online` ones, taken from the low bits, before it is stored. A count of 8 or more keeps all bits, and a count of 0 stores zero.
- R6: The destination index of a shared line is the bit position of the lowest set bit of its mask, or 0 when the mask is zero.
- R7: A destination index changes only at the clock edge that accepts a write to its line. The new value is visible after that edge and not before it.
- R8: A lane whose interrupt number is at or above `NUM_IRQ` reads as zero, and a write through that lane is ignored.
- R9: `rd_data` is registered. It is loaded at the edge where `acc_rd` is high, holds otherwise, and returns the masks as they were before a write accepted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| acc_addr | input | ADDR_W (7) | Byte offset into the target window |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wdata | input | 32 | Write data, byte lane i for interrupt base+i |
| cpus_online | input | CNT_W (4) | Number of online processors |
| acc_cpu | input | IDX_W (3) | Index of the processor making the access |
| rd_data | output | 32 | Registered read data |
| dest_idx | output | (NUM_IRQ-NUM_PRIV)*IDX_W (96) | Resolved destination per shared line, line 32+j in bits [3j+2:3j] |

## Verification
The read path and the write path can act in the same cycle on the same word. The bench provokes this by raising `acc_rd` and `acc_wr` together on a word whose content is known. It then expects `rd_data` to show the old masks, while the following read and the destination outputs show the new ones. A second overlap arises when a write lands on one line while the destination of that line is being sampled. The bench probes the destination just before the accepting edge and again just after it, to judge the one-edge update.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

  // Number of byte lanes in a word access; each lane maps to one interrupt.
  localparam int LANES = 4;

  // Access size as seen on acc_wide.
  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;

endpackage

// File: rtl/tgt_mask_gen.sv
module tgt_mask_gen #(
  parameter int FIELD_W = 8,
  parameter int CNT_W   = $clog2(FIELD_W) + 1
) (
  input  logic [CNT_W-1:0]   online_cnt,
  output logic [FIELD_W-1:0] keep_mask
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIELD_W);

  logic [FIELD_W:0] one_hot;

  always_comb begin
    one_hot = (FIELD_W+1)'(1) << online_cnt;
    if (online_cnt >= FULL_CNT) begin
      keep_mask = '1;
    end else begin
      keep_mask = one_hot[FIELD_W-1:0] - FIELD_W'(1);
    end
  end

endmodule

// File: rtl/tgt_lane_decode.sv
module tgt_lane_decode
  import tgt_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32,
  parameter int FIELD_W  = 8,
  parameter int ADDR_W   = $clog2(NUM_IRQ) + 1
) (
  input  logic [ADDR_W-1:0]                 acc_addr,
  input  logic                              acc_wide,
  input  logic                              acc_wr,
  input  logic [LANES*FIELD_W-1:0]          acc_wdata,
  output logic [LANES-1:0][ADDR_W-1:0]      lane_irq,
  output logic [LANES-1:0]                  lane_live,
  output logic [LANES-1:0]                  lane_priv,
  output logic [LANES-1:0]                  lane_wen,
  output logic [LANES-1:0][FIELD_W-1:0]     lane_wbyte
);

  localparam logic [ADDR_W:0] LIM_IRQ  = (ADDR_W+1)'(NUM_IRQ);
  localparam logic [ADDR_W:0] LIM_PRIV = (ADDR_W+1)'(NUM_PRIV);

  acc_size_e         size;
  logic [ADDR_W-1:0] base;

  always_comb begin
    size = acc_size_e'(acc_wide);
    if (size == ACC_WORD) begin
      base = {acc_addr[ADDR_W-1:2], 2'b00};
    end else begin
      base = acc_addr;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W:0] num;
    logic            sel;

    always_comb begin
      num           = {1'b0, base} + (ADDR_W+1)'(i);
      sel           = (size == ACC_WORD) || (i == 0);
      lane_irq[i]   = num[ADDR_W-1:0];
      lane_live[i]  = sel && (num < LIM_IRQ);
      lane_priv[i]  = num < LIM_PRIV;
      lane_wen[i]   = acc_wr && lane_live[i] && !lane_priv[i];
      if (size == ACC_WORD) begin
        lane_wbyte[i] = acc_wdata[i*FIELD_W +: FIELD_W];
      end else begin
        lane_wbyte[i] = acc_wdata[FIELD_W-1:0];
      end
    end
  end

endmodule

// File: rtl/tgt_field.sv
module tgt_field
  import tgt_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int IDX_W   = $clog2(FIELD_W),
  parameter int ADDR_W  = 7,
  parameter int IRQ_ID  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0][ADDR_W-1:0]  lane_irq,
  input  logic [LANES-1:0]              lane_wen,
  input  logic [LANES-1:0][FIELD_W-1:0] lane_wbyte,
  input  logic [FIELD_W-1:0]            keep_mask,
  output logic [FIELD_W-1:0]            field_q,
  output logic [IDX_W-1:0]              dest_q
);

  localparam logic [ADDR_W-1:0] MY_ID = ADDR_W'(IRQ_ID);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [FIELD_W-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int b = FIELD_W - 1; b >= 0; b--) begin
      if (m[b]) r = IDX_W'(b);
    end
    return r;
  endfunction

  logic               hit;
  logic [FIELD_W-1:0] field_d;
  logic [IDX_W-1:0]   dest_d;

  // Next-state: pick the lane that addresses this line, clip, resolve.
  always_comb begin
    hit     = 1'b0;
    field_d = field_q;
    for (int i = 0; i < LANES; i++) begin
      if (lane_wen[i] && (lane_irq[i] == MY_ID)) begin
        hit     = 1'b1;
        field_d = lane_wbyte[i] & keep_mask;
      end
    end
    dest_d = lowest_set(field_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      dest_q  <= '0;
    end else if (hit) begin
      field_q <= field_d;
      dest_q  <= dest_d;
    end
  end

endmodule

// File: rtl/tgt_read_mux.sv
module tgt_read_mux
  import tgt_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32,
  parameter int FIELD_W  = 8,
  parameter int IDX_W    = $clog2(FIELD_W),
  parameter int ADDR_W   = $clog2(NUM_IRQ) + 1
) (
  input  logic [NUM_IRQ-NUM_PRIV-1:0][FIELD_W-1:0] fields,
  input  logic [LANES-1:0][ADDR_W-1:0]             lane_irq,
  input  logic [LANES-1:0]                         lane_live,
  input  logic [LANES-1:0]                         lane_priv,
  input  logic [IDX_W-1:0]                         acc_cpu,
  output logic [LANES*FIELD_W-1:0]                 rd_next
);

  localparam int NUM_SHARED = NUM_IRQ - NUM_PRIV;

  logic [FIELD_W-1:0] own_bit;

  always_comb begin
    own_bit = FIELD_W'(1) << acc_cpu;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [FIELD_W-1:0] pick;

    always_comb begin
      pick = '0;
      for (int j = 0; j < NUM_SHARED; j++) begin
        if (lane_irq[i] == ADDR_W'(j + NUM_PRIV)) pick = fields[j];
      end
      if (!lane_live[i]) begin
        rd_next[i*FIELD_W +: FIELD_W] = '0;
      end else if (lane_priv[i]) begin
        rd_next[i*FIELD_W +: FIELD_W] = own_bit;
      end else begin
        rd_next[i*FIELD_W +: FIELD_W] = pick;
      end
    end
  end

endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank
  import tgt_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32,
  parameter int FIELD_W  = 8,
  parameter int IDX_W    = $clog2(FIELD_W),
  parameter int CNT_W    = $clog2(FIELD_W) + 1,
  parameter int ADDR_W   = $clog2(NUM_IRQ) + 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   acc_addr,
  input  logic                                acc_wide,
  input  logic                                acc_wr,
  input  logic                                acc_rd,
  input  logic [4*FIELD_W-1:0]                acc_wdata,
  input  logic [CNT_W-1:0]                    cpus_online,
  input  logic [IDX_W-1:0]                    acc_cpu,
  output logic [4*FIELD_W-1:0]                rd_data,
  output logic [(NUM_IRQ-NUM_PRIV)*IDX_W-1:0] dest_idx
);

  localparam int NUM_SHARED = NUM_IRQ - NUM_PRIV;
  localparam int DATA_W     = LANES * FIELD_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [LANES-1:0][ADDR_W-1:0]      lane_irq;
  logic [LANES-1:0]                  lane_live;
  logic [LANES-1:0]                  lane_priv;
  logic [LANES-1:0]                  lane_wen;
  logic [LANES-1:0][FIELD_W-1:0]     lane_wbyte;
  logic [FIELD_W-1:0]                keep_mask;
  logic [NUM_SHARED-1:0][FIELD_W-1:0] fields;
  logic [DATA_W-1:0]                 rd_next;
  logic [DATA_W-1:0]                 rd_q;

  tgt_lane_decode #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_PRIV(NUM_PRIV),
    .FIELD_W (FIELD_W),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .acc_addr  (acc_addr),
    .acc_wide  (acc_wide),
    .acc_wr    (acc_wr),
    .acc_wdata (acc_wdata),
    .lane_irq  (lane_irq),
    .lane_live (lane_live),
    .lane_priv (lane_priv),
    .lane_wen  (lane_wen),
    .lane_wbyte(lane_wbyte)
  );

  tgt_mask_gen #(
    .FIELD_W(FIELD_W),
    .CNT_W  (CNT_W)
  ) u_mask (
    .online_cnt(cpus_online),
    .keep_mask (keep_mask)
  );

  for (genvar j = 0; j < NUM_SHARED; j++) begin : g_line
    tgt_field #(
      .FIELD_W(FIELD_W),
      .IDX_W  (IDX_W),
      .ADDR_W (ADDR_W),
      .IRQ_ID (NUM_PRIV + j)
    ) u_field (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .lane_irq  (lane_irq),
      .lane_wen  (lane_wen),
      .lane_wbyte(lane_wbyte),
      .keep_mask (keep_mask),
      .field_q   (fields[j]),
      .dest_q    (dest_idx[j*IDX_W +: IDX_W])
    );
  end

  tgt_read_mux #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_PRIV(NUM_PRIV),
    .FIELD_W (FIELD_W),
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W)
  ) u_rmux (
    .fields   (fields),
    .lane_irq (lane_irq),
    .lane_live(lane_live),
    .lane_priv(lane_priv),
    .acc_cpu  (acc_cpu),
    .rd_next  (rd_next)
  );

  // Read data register, loaded only on a read strobe.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (acc_rd) begin
      rd_q <= rd_next;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/tgt_bank_chk.sv
module tgt_bank_chk #(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32,
  parameter int FIELD_W  = 8,
  parameter int IDX_W    = $clog2(FIELD_W),
  parameter int ADDR_W   = $clog2(NUM_IRQ) + 1
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [ADDR_W-1:0]                   acc_addr,
  input logic                                acc_wide,
  input logic                                acc_wr,
  input logic                                acc_rd,
  input logic [IDX_W-1:0]                    acc_cpu,
  input logic [4*FIELD_W-1:0]                rd_data,
  input logic [(NUM_IRQ-NUM_PRIV)*IDX_W-1:0] dest_idx
);

  localparam logic [ADDR_W-1:0] PRIV_A = ADDR_W'(NUM_PRIV);
  localparam logic [ADDR_W:0]   IRQ_A  = (ADDR_W+1)'(NUM_IRQ);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(rd_data)); // R9

  AST_DEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(dest_idx)); // R7

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wide) |=> (rd_data[4*FIELD_W-1:FIELD_W] == '0)); // R3

  AST_PRIV_OWN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wide && (acc_addr < PRIV_A))
      |=> (rd_data == ((4*FIELD_W)'(1) << $past(acc_cpu)))); // R4

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wide && ({1'b0, acc_addr} >= IRQ_A)) |=> (rd_data == '0)); // R8

endmodule

bind irq_target_bank tgt_bank_chk #(
  .NUM_IRQ (NUM_IRQ),
  .NUM_PRIV(NUM_PRIV),
  .FIELD_W (FIELD_W),
  .IDX_W   (IDX_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .acc_addr(acc_addr),
  .acc_wide(acc_wide),
  .acc_wr  (acc_wr),
  .acc_rd  (acc_rd),
  .acc_cpu (acc_cpu),
  .rd_data (rd_data),
  .dest_idx(dest_idx)
);

// File: tb/tb_irq_target_bank.sv
`timescale 1ns/1ps
module tb_irq_target_bank;

  logic        clk;
  logic        rst_n;
  logic [6:0]  acc_addr;
  logic        acc_wide;
  logic        acc_wr;
  logic        acc_rd;
  logic [31:0] acc_wdata;
  logic [3:0]  cpus_online;
  logic [2:0]  acc_cpu;
  logic [31:0] rd_data;
  logic [95:0] dest_idx;

  int n_chk  = 0;
  int n_fail = 0;

  irq_target_bank dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wide(acc_wide),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_wdata(acc_wdata),
    .cpus_online(cpus_online), .acc_cpu(acc_cpu),
    .rd_data(rd_data), .dest_idx(dest_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  typedef struct packed {
    logic        rd;      // 1 = read and compare, 0 = write
    logic        wide;
    logic [6:0]  addr;
    logic [31:0] data;    // write data or expected read data
    logic [3:0]  online;
    logic [2:0]  cpu;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 7'd32,  32'h0C33F100, 4'd4, 3'd2, 4'd5}, // R5 write, 4 cpus
    '{1'b1, 1'b1, 7'd32,  32'h0C030100, 4'd4, 3'd2, 4'd2}, // R2 lanes, R5 clip
    '{1'b0, 1'b0, 7'd37,  32'h000000A6, 4'd8, 3'd2, 4'd3}, // R3 byte write
    '{1'b1, 1'b0, 7'd37,  32'h000000A6, 4'd8, 3'd2, 4'd3}, // R3 byte read
    '{1'b1, 1'b1, 7'd36,  32'h0000A600, 4'd8, 3'd2, 4'd2}, // R2 lane 1
    '{1'b0, 1'b1, 7'd4,   32'hFFFFFFFF, 4'd8, 3'd2, 4'd4}, // R4 private write
    '{1'b1, 1'b1, 7'd4,   32'h04040404, 4'd8, 3'd2, 4'd4}, // R4 own bit
    '{1'b1, 1'b0, 7'd10,  32'h00000020, 4'd8, 3'd5, 4'd4}, // R4 own bit cpu5
    '{1'b0, 1'b1, 7'd66,  32'hFFFFFFFF, 4'd8, 3'd0, 4'd8}, // R8 write beyond
    '{1'b1, 1'b1, 7'd64,  32'h00000000, 4'd8, 3'd0, 4'd8}, // R8 read beyond
    '{1'b1, 1'b0, 7'd127, 32'h00000000, 4'd8, 3'd0, 4'd8}, // R8 top byte
    '{1'b0, 1'b1, 7'd42,  32'h11223344, 4'd2, 3'd0, 4'd2}, // R2 low bits dropped
    '{1'b1, 1'b1, 7'd40,  32'h01020300, 4'd2, 3'd0, 4'd5}, // R5 two cpus
    '{1'b0, 1'b0, 7'd33,  32'h000000FF, 4'd0, 3'd0, 4'd5}, // R5 zero cpus
    '{1'b1, 1'b0, 7'd33,  32'h00000000, 4'd0, 3'd0, 4'd5}, // R5
    '{1'b1, 1'b0, 7'd35,  32'h0000000C, 4'd0, 3'd0, 4'd3}  // R3 upper zero
  };

  vec_t v;

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] dest_of(input int irq);
    return dest_idx[(irq - 32) * 3 +: 3];
  endfunction

  task automatic access(input logic wr, input logic rd, input logic wide,
                        input logic [6:0] addr, input logic [31:0] data,
                        input logic [3:0] online, input logic [2:0] cpu);
    @(negedge clk);
    acc_wr = wr; acc_rd = rd; acc_wide = wide; acc_addr = addr;
    acc_wdata = data; cpus_online = online; acc_cpu = cpu;
    @(negedge clk);
    acc_wr = 1'b0; acc_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_wr = 1'b0; acc_rd = 1'b0; acc_wide = 1'b0;
    acc_addr = '0; acc_wdata = '0; cpus_online = 4'd8; acc_cpu = '0;
    repeat (4) @(negedge clk);
    check32("R1 rd_data in reset", rd_data, 32'h0);
    check32("R1 dest in reset", {29'h0, dest_of(40)}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 1'b1, 1'b1, 7'd48, 32'h0, 4'd8, 3'd0);
    check32("R1 mask after reset", rd_data, 32'h0);

    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      access(!v.rd, v.rd, v.wide, v.addr, v.data, v.online, v.cpu);
      if (v.rd) check32($sformatf("R%0d vector %0d", v.req, k), rd_data, v.data);
    end

    // R6: lowest set bit, zero mask gives 0
    check32("R6 dest 35 mask 0C", {29'h0, dest_of(35)}, 32'd2);
    check32("R6 dest 37 mask A6", {29'h0, dest_of(37)}, 32'd1);
    check32("R6 dest 42 mask 02", {29'h0, dest_of(42)}, 32'd1);
    check32("R6 dest 43 mask 01", {29'h0, dest_of(43)}, 32'd0);
    check32("R6 dest 33 mask 00", {29'h0, dest_of(33)}, 32'd0);

    // R7: destination moves at the accepting edge, not before
    @(negedge clk);
    acc_wr = 1'b1; acc_wide = 1'b0; acc_addr = 7'd50; acc_wdata = 32'h10; cpus_online = 4'd8;
    #1;
    check32("R7 dest before edge", {29'h0, dest_of(50)}, 32'd0);
    @(negedge clk);
    acc_wr = 1'b0;
    check32("R7 dest after edge", {29'h0, dest_of(50)}, 32'd4);

    // R9: read and write of the same word in one cycle
    @(negedge clk);
    acc_wr = 1'b1; acc_rd = 1'b1; acc_wide = 1'b1; acc_addr = 7'd32;
    acc_wdata = 32'h80808080; cpus_online = 4'd8;
    @(negedge clk);
    acc_wr = 1'b0; acc_rd = 1'b0;
    check32("R9 same-cycle read returns old", rd_data, 32'h0C030000);
    check32("R6 dest 35 mask 80", {29'h0, dest_of(35)}, 32'd7);
    @(negedge clk);
    check32("R9 rd_data holds without strobe", rd_data, 32'h0C030000);
    access(1'b0, 1'b1, 1'b1, 7'd32, 32'h0, 4'd8, 3'd0);
    check32("R9 next read returns new", rd_data, 32'h80808080);

    // R1: reset during operation clears state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check32("R1 rd_data cleared", rd_data, 32'h0);
    check32("R1 dest cleared", {29'h0, dest_of(35)}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 1'b1, 1'b1, 7'd32, 32'h0, 4'd8, 3'd0);
    check32("R1 masks cleared", rd_data, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule